// File: doc/BRIEF.md
# Video Clock Divider Tap Tree

This block turns a stream of fast-clock enable pulses from a video PLL into per-consumer pixel clock enables. All of it is modelled as single-cycle strobes in one fast clock domain, and no clock is generated. One source is chosen from several candidate enable inputs. A programmable integer pre-divider thins that source by a ratio of one to 256. The pre-divided pulse then feeds a bank of five fixed taps that divide it further by 1, 2, 4, 6 and 12. Each tap has its own gate.

Four consumers each pick one tap through a 4-bit selector and have their own output enable. The consumers are the interlaced encoder, the progressive encoder, the DAC and the HDMI transmitter pixel path. All settings are static register-style inputs. A soft-reset pulse and a pre-divider reset both bring the tap counters back into phase. Software programs the ratio, the taps and the selectors, then pulses the soft reset. From that point the consumer strobes run at phase-aligned rates. For example, a ratio field of 54 turns a 1485 MHz strobe stream into a 27 MHz one.

Top module: `vclk_tap_tree`

## Requirements
- R1: While `rst_n` is low, every bit of `cons_stb_o` is 0.
- R2: With a ratio field value N, the pre-divider emits one pulse for every N+1 counted source pulses. The field holds the ratio minus one.
- R3: Tap k emits one strobe for every D pre-divided pulses, where D is 1, 2, 4, 6 or 12 for k = 0, 1, 2, 3, 4. A tap fires on the first pulse after a clear and then on every D-th pulse.
- R4: A tap whose bit in `tap_en_i` (bit k for tap k) is 0 produces no strobe on any consumer that selects it.
- R5: Consumer c reads its selector from `cons_sel_i[4c+3:4c]`. Codes 0 to 4 pick taps /1, /2, /4, /6 and /12 in that order. Codes 5 to 15 give no strobes.
- R6: Consumer c strobes only while `cons_en_i[c]` is 1. Consumer 0 is the interlaced encoder, 1 the progressive encoder, 2 the DAC and 3 the HDMI transmitter pixel path.
- R7: While `master_en_i` is 0, no source pulse is counted and the pre-divider count holds its value. Two cycles after it falls, the consumer strobes stop.
- R8: Only pulses on `src_en_i[src_sel_i]` are counted. A select value at or above the number of sources counts nothing.
- R9: While `prediv_en_i` is 0, the pre-divider count holds its value. A cycle with `prediv_rst_i` high clears the pre-divider count and every tap counter, and suppresses strobes in the following cycle.
- R10: While `soft_rst_i` is high, no consumer strobes and the tap counters return to zero. The first pre-divided pulse after release fires every enabled tap at once.
- R11: A consumer strobe is high in the cycle after the clock edge that follows the edge sampling the source pulse that completes the pre-divider count. This is two edges of latency.
- R12: A selector change applies from the next pre-divided pulse on. The tap counters run regardless of selection and gating, so a newly chosen tap keeps its own phase and no partial period appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en_i | input | SRC_NUM (8) | Candidate source enable strobes |
| src_sel_i | input | SRC_SEL_W (3) | Source select |
| master_en_i | input | 1 | Master enable for the divided path |
| prediv_ratio_m1_i | input | RATIO_W (8) | Pre-divider ratio minus one |
| prediv_rst_i | input | 1 | Pre-divider reset, clears all counters |
| prediv_en_i | input | 1 | Pre-divider count enable |
| soft_rst_i | input | 1 | Tap resynchronisation pulse |
| tap_en_i | input | 5 | Per-tap gates, bit k for tap k |
| cons_sel_i | input | NUM_CONS*SEL_W (16) | Per-consumer tap selectors |
| cons_en_i | input | NUM_CONS (4) | Per-consumer output enables |
| cons_stb_o | output | NUM_CONS (4) | Per-consumer pixel clock enable strobes |

## Verification
A wrong pre-divider count shows at the ports as a shifted first strobe, at most one ratio period after a resync. That ratio period is up to 256 source pulses. A tap counter out of phase shows as strobes on the wrong pre-divided pulses within one tap period, at most 12 pulses. A soft reset that fails to realign the counters shows on the very first pulse after release, because the four consumers on different taps do not strobe together. Selector, gate and enable faults show within one period of the chosen tap.

// File: rtl/vclk_tap_pkg.sv
package vclk_tap_pkg;
   // number of fixed sub-divider taps and their counter width
   localparam int NUM_TAPS  = 5;
   localparam int TAP_MAX   = 12;
   localparam int TAP_CNT_W = $clog2(TAP_MAX);

   // consumer slot order on the selector and strobe buses
   localparam int CONS_INTERLACED  = 0;
   localparam int CONS_PROGRESSIVE = 1;
   localparam int CONS_DAC         = 2;
   localparam int CONS_HDMI_PIX    = 3;

   // division factor of tap k; the order is the selector code order
   function automatic int tap_div(input int k);
      case (k)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 6;
         default: return 12;
      endcase
   endfunction
endpackage

// File: rtl/vclk_prediv.sv
module vclk_prediv #(
   parameter int SRC_NUM   = 8,
   parameter int SRC_SEL_W = 3,
   parameter int RATIO_W   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SRC_NUM-1:0]   src_en,
   input  logic [SRC_SEL_W-1:0] src_sel,
   input  logic                 master_en,
   input  logic                 div_en,
   input  logic                 div_rst,
   input  logic [RATIO_W-1:0]   ratio_m1,
   output logic                 pulse
);
   logic [RATIO_W-1:0] cnt;
   logic               src_hit;
   logic               advance;
   logic               at_end;

   always_comb begin
      src_hit = 1'b0;
      for (int i = 0; i < SRC_NUM; i++) begin
         if (src_sel == SRC_SEL_W'(i)) src_hit = src_en[i];
      end
   end

   assign advance = src_hit & master_en & div_en;
   // terminal compare tolerates a ratio lowered below the running count
   assign at_end  = (cnt >= ratio_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (div_rst) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= advance & at_end;
         if (advance) cnt <= at_end ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vclk_tap_bank.sv
module vclk_tap_bank
   import vclk_tap_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pulse,
   input  logic                sync_clr,
   input  logic [NUM_TAPS-1:0] tap_en,
   output logic [NUM_TAPS-1:0] tap_fire
);
   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      localparam int DIV = tap_div(k);
      if (DIV == 1) begin : g_pass
         assign tap_fire[k] = pulse & tap_en[k] & ~sync_clr;
      end else begin : g_cnt
         logic [TAP_CNT_W-1:0] phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (sync_clr) begin
               phase <= '0;
            end else if (pulse) begin
               phase <= (phase == TAP_CNT_W'(DIV - 1)) ? '0 : phase + 1'b1;
            end
         end
         assign tap_fire[k] = pulse & tap_en[k] & ~sync_clr & (phase == '0);
      end
   end
endmodule

// File: rtl/vclk_cons_mux.sv
module vclk_cons_mux
   import vclk_tap_pkg::*;
#(
   parameter int NUM_CONS = 4,
   parameter int SEL_W    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_TAPS-1:0]       tap_fire,
   input  logic [NUM_CONS*SEL_W-1:0] cons_sel,
   input  logic [NUM_CONS-1:0]       cons_en,
   output logic [NUM_CONS-1:0]       cons_stb
);
   for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
      logic [SEL_W-1:0] code;
      logic             hit;
      logic             stb_q;

      assign code = cons_sel[c*SEL_W +: SEL_W];

      // codes past the last tap match nothing and stay silent
      always_comb begin
         hit = 1'b0;
         for (int t = 0; t < NUM_TAPS; t++) begin
            if (code == SEL_W'(t)) hit = tap_fire[t];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stb_q <= 1'b0;
         else        stb_q <= hit & cons_en[c];
      end

      assign cons_stb[c] = stb_q;
   end
endmodule

// File: rtl/vclk_tap_tree.sv
module vclk_tap_tree
   import vclk_tap_pkg::*;
#(
   parameter int SRC_NUM   = 8,
   parameter int SRC_SEL_W = 3,
   parameter int RATIO_W   = 8,
   parameter int NUM_CONS  = 4,
   parameter int SEL_W     = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SRC_NUM-1:0]        src_en_i,
   input  logic [SRC_SEL_W-1:0]      src_sel_i,
   input  logic                      master_en_i,
   input  logic [RATIO_W-1:0]        prediv_ratio_m1_i,
   input  logic                      prediv_rst_i,
   input  logic                      prediv_en_i,
   input  logic                      soft_rst_i,
   input  logic [NUM_TAPS-1:0]       tap_en_i,
   input  logic [NUM_CONS*SEL_W-1:0] cons_sel_i,
   input  logic [NUM_CONS-1:0]       cons_en_i,
   output logic [NUM_CONS-1:0]       cons_stb_o
);
   // elaboration-time parameter checks
   if (SRC_NUM < 1 || SRC_NUM > (1 << SRC_SEL_W)) begin : g_bad_src
      $error("vclk_tap_tree: SRC_NUM does not fit SRC_SEL_W");
   end
   if ((1 << SEL_W) < NUM_TAPS) begin : g_bad_sel
      $error("vclk_tap_tree: SEL_W too narrow for the tap set");
   end
   if (RATIO_W < 1) begin : g_bad_ratio
      $error("vclk_tap_tree: RATIO_W must be positive");
   end

   logic                pdiv_pulse;
   logic                sync_clr;
   logic [NUM_TAPS-1:0] tap_fire;

   // both reset controls bring the tap counters back into phase
   assign sync_clr = soft_rst_i | prediv_rst_i;

   vclk_prediv #(
      .SRC_NUM  (SRC_NUM),
      .SRC_SEL_W(SRC_SEL_W),
      .RATIO_W  (RATIO_W)
   ) u_prediv (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_en   (src_en_i),
      .src_sel  (src_sel_i),
      .master_en(master_en_i),
      .div_en   (prediv_en_i),
      .div_rst  (prediv_rst_i),
      .ratio_m1 (prediv_ratio_m1_i),
      .pulse    (pdiv_pulse)
   );

   vclk_tap_bank u_taps (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse   (pdiv_pulse),
      .sync_clr(sync_clr),
      .tap_en  (tap_en_i),
      .tap_fire(tap_fire)
   );

   vclk_cons_mux #(
      .NUM_CONS(NUM_CONS),
      .SEL_W   (SEL_W)
   ) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .tap_fire(tap_fire),
      .cons_sel(cons_sel_i),
      .cons_en (cons_en_i),
      .cons_stb(cons_stb_o)
   );
endmodule

// File: rtl/vclk_tap_tree_chk.sv
module vclk_tap_tree_chk
   import vclk_tap_pkg::*;
#(
   parameter int SRC_NUM   = 8,
   parameter int SRC_SEL_W = 3,
   parameter int RATIO_W   = 8,
   parameter int NUM_CONS  = 4,
   parameter int SEL_W     = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      master_en_i,
   input logic                      prediv_rst_i,
   input logic                      prediv_en_i,
   input logic                      soft_rst_i,
   input logic [NUM_CONS*SEL_W-1:0] cons_sel_i,
   input logic [NUM_CONS-1:0]       cons_en_i,
   input logic [NUM_CONS-1:0]       cons_stb_o
);
   // R6
   cons_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_stb_o & ~$past(cons_en_i)) == '0);

   // R7
   master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(master_en_i, 2) |-> cons_stb_o == '0);

   // R9
   prediv_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prediv_rst_i) |-> cons_stb_o == '0);

   // R9
   prediv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prediv_en_i, 2) |-> cons_stb_o == '0);

   // R10
   soft_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst_i) |-> cons_stb_o == '0);

   for (genvar c = 0; c < NUM_CONS; c++) begin : g_sel
      // R5
      sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cons_stb_o[c] |-> ($past(cons_sel_i[c*SEL_W +: SEL_W]) < SEL_W'(NUM_TAPS)));
   end
endmodule

bind vclk_tap_tree vclk_tap_tree_chk #(
   .SRC_NUM  (SRC_NUM),
   .SRC_SEL_W(SRC_SEL_W),
   .RATIO_W  (RATIO_W),
   .NUM_CONS (NUM_CONS),
   .SEL_W    (SEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_en_i (master_en_i),
   .prediv_rst_i(prediv_rst_i),
   .prediv_en_i (prediv_en_i),
   .soft_rst_i  (soft_rst_i),
   .cons_sel_i  (cons_sel_i),
   .cons_en_i   (cons_en_i),
   .cons_stb_o  (cons_stb_o)
);

// File: tb/sim_vclk_tap_tree.sv
module sim_vclk_tap_tree;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_en = '1;
   logic [2:0]  src_sel = '0;
   logic        master_en = 1'b1;
   logic [7:0]  ratio_m1 = '0;
   logic        prediv_rst = 1'b0;
   logic        prediv_en = 1'b1;
   logic        soft_rst = 1'b0;
   logic [4:0]  tap_en = '1;
   logic [15:0] cons_sel = '0;
   logic [3:0]  cons_en = '1;
   logic [3:0]  cons_stb;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cnt[4];
   int first[4];

   always #(CLK_PERIOD/2) clk = ~clk;

   vclk_tap_tree u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .src_en_i         (src_en),
      .src_sel_i        (src_sel),
      .master_en_i      (master_en),
      .prediv_ratio_m1_i(ratio_m1),
      .prediv_rst_i     (prediv_rst),
      .prediv_en_i      (prediv_en),
      .soft_rst_i       (soft_rst),
      .tap_en_i         (tap_en),
      .cons_sel_i       (cons_sel),
      .cons_en_i        (cons_en),
      .cons_stb_o       (cons_stb)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int div_of(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 4;
         3: return 6;
         default: return 12;
      endcase
   endfunction

   // strobes in samples 1..len after a counter clear, continuous source
   function automatic int exp_count(input int len, input int n, input int d);
      if (len < n + 2) return 0;
      return (len - n - 2) / ((n + 1) * d) + 1;
   endfunction

   task automatic clear_acc();
      for (int c = 0; c < 4; c++) begin
         cnt[c] = 0;
         first[c] = 0;
      end
   endtask

   task automatic accum(input int i);
      for (int c = 0; c < 4; c++) begin
         if (cons_stb[c]) begin
            cnt[c]++;
            if (first[c] == 0) first[c] = i;
         end
      end
   endtask

   task automatic set_defaults();
      src_en = '1; src_sel = '0; master_en = 1'b1; ratio_m1 = '0;
      prediv_rst = 1'b0; prediv_en = 1'b1; soft_rst = 1'b0;
      tap_en = '1; cons_sel = '0; cons_en = '1;
   endtask

   // clears all counters; returns on the negedge before the first live edge
   task automatic sync_start();
      @(negedge clk); prediv_rst = 1'b1;
      @(negedge clk); prediv_rst = 1'b0;
   endtask

   task automatic run_window(input int len);
      clear_acc();
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         accum(i);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 strobes low in reset", int'(cons_stb), 0);
   endtask

   task automatic t_divide();
      set_defaults();
      ratio_m1 = 8'd54;
      cons_sel = {4'd3, 4'd4, 4'd1, 4'd0};
      sync_start();
      run_window(400);
      check("R2 ratio 55 on tap /1", cnt[0], exp_count(400, 54, 1));
      check("R3 ratio 55 on tap /2", cnt[1], exp_count(400, 54, 2));
      check("R3 ratio 55 on tap /12", cnt[2], exp_count(400, 54, 12));
      check("R3 ratio 55 on tap /6", cnt[3], exp_count(400, 54, 6));
      check("R11 first strobe sample", first[0], 56);
   endtask

   task automatic t_soft_align();
      set_defaults();
      cons_sel = {4'd4, 4'd3, 4'd2, 4'd1};
      sync_start();
      run_window(7);
      soft_rst = 1'b1;
      @(negedge clk);
      check("R10 quiet during soft reset", int'(cons_stb), 0);
      soft_rst = 1'b0;
      @(negedge clk);
      check("R10 all taps aligned after release", int'(cons_stb), 15);
      run_window(11);
      for (int c = 0; c < 4; c++) begin
         check("R3 tap rate after resync", cnt[c] + 1, 12 / div_of(c + 1));
      end
   endtask

   task automatic t_gate();
      set_defaults();
      ratio_m1 = 8'd1;
      tap_en = 5'b11011;
      cons_sel = {4'd2, 4'd2, 4'd1, 4'd0};
      sync_start();
      run_window(40);
      check("R4 open tap /1", cnt[0], exp_count(40, 1, 1));
      check("R4 open tap /2", cnt[1], exp_count(40, 1, 2));
      check("R4 gated tap consumer 2", cnt[2], 0);
      check("R4 gated tap consumer 3", cnt[3], 0);
   endtask

   task automatic t_badsel();
      set_defaults();
      cons_sel = {4'd7, 4'd2, 4'd15, 4'd5};
      sync_start();
      run_window(30);
      check("R5 code 5 silent", cnt[0], 0);
      check("R5 code 15 silent", cnt[1], 0);
      check("R5 code 2 is tap /4", cnt[2], exp_count(30, 0, 4));
      check("R5 code 7 silent", cnt[3], 0);
   endtask

   task automatic t_outen();
      set_defaults();
      ratio_m1 = 8'd2;
      cons_en = 4'b0101;
      sync_start();
      run_window(30);
      check("R6 interlaced enabled", cnt[0], exp_count(30, 2, 1));
      check("R6 progressive disabled", cnt[1], 0);
      check("R6 DAC enabled", cnt[2], exp_count(30, 2, 1));
      check("R6 HDMI pixel disabled", cnt[3], 0);
   endtask

   task automatic t_hold(input bit use_master, input string req);
      set_defaults();
      ratio_m1 = 8'd3;
      sync_start();
      clear_acc();
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         accum(i);
         if (i == 2) begin
            if (use_master) master_en = 1'b0; else prediv_en = 1'b0;
         end
         if (i == 7) begin
            master_en = 1'b1; prediv_en = 1'b1;
         end
      end
      check({req, " count held, first strobe"}, first[0], 10);
      check({req, " strobes after resume"}, cnt[0], 3);
   endtask

   task automatic t_master_off();
      set_defaults();
      master_en = 1'b0;
      sync_start();
      run_window(20);
      check("R7 no strobes with master off", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
   endtask

   task automatic t_src();
      set_defaults();
      ratio_m1 = 8'd2;
      src_en = 8'b0000_1000;
      src_sel = 3'd3;
      sync_start();
      run_window(30);
      check("R8 selected source counted", cnt[0], exp_count(30, 2, 1));
      set_defaults();
      ratio_m1 = 8'd2;
      src_en = 8'b0000_1000;
      src_sel = 3'd5;
      sync_start();
      run_window(30);
      check("R8 idle source gives nothing", cnt[0], 0);
   endtask

   task automatic t_selchg();
      int bad = 0;
      set_defaults();
      cons_sel = {12'd0, 4'd2};
      sync_start();
      for (int i = 1; i <= 14; i++) begin
         bit e;
         @(negedge clk);
         if (i <= 7) e = (i >= 2) && ((i - 2) % 4 == 0);
         else        e = (i - 2) % 2 == 0;
         if (cons_stb[0] != e) bad++;
         if (i == 7) cons_sel = {12'd0, 4'd1};
      end
      check("R12 selector change keeps tap phase", bad, 0);
   endtask

   initial begin
      set_defaults();
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_divide();
      t_soft_align();
      t_gate();
      t_badsel();
      t_outen();
      t_hold(1'b1, "R7");
      t_hold(1'b0, "R9");
      t_master_off();
      t_src();
      t_selchg();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule